// File: doc/BRIEF.md
# Priority and Group-Adaptive Output Arbiter

This block sits between the header decoders and the crossbar of a packet switch that uses wormhole switching. Every input port that has decoded a packet header shows a request. The request carries the set of output ports that may carry the packet and one priority bit, both looked up earlier from the routing entry for the packet's address. Each cycle the arbiter decides which waiting inputs are connected to which outputs. A connection stays in place until that input signals that its end-of-packet marker has passed.

When a routing entry lists more than one output, any of them is acceptable. The arbiter steers the packet to the lowest-numbered listed output that is idle. If all the listed outputs are taken, the request waits and takes whichever listed output is released first. When several inputs compete for one idle output, a high-priority request beats a normal one. Among requests of equal priority, a rotating pointer kept for each output shares the output fairly.

Top module: `prio_group_arbiter`

## Requirements
- R1: After reset, no input is connected, every output reads free, every `grant_port` reads 0, and every output's rotation pointer starts at input 0.
- R2: A valid request from an unconnected input whose bitmap names a free output is connected at the next rising edge. `grant_valid`, `grant_port` (the binary output index) and the matching `out_busy` bit are all visible one cycle after the request.
- R3: In `req_ports[i]`, bit k means that output k may carry the packet. The output granted is the lowest-indexed bit that is both set and free. If none is free, the request waits and is granted a listed output once that output becomes free.
- R4: Among inputs contending for the same free output, any input with `req_prio` = 1 wins over inputs with `req_prio` = 0, whatever the rotation pointer holds.
- R5: Among contenders of equal priority, an output grants the first contender at or after its pointer, wrapping past the last input. After each grant the pointer moves to the granted input plus one, modulo the number of inputs.
- R6: A connection holds its output and `grant_port` unchanged until `pkt_end` for that input. Requests from other inputs for that output get no grant meanwhile.
- R7: `pkt_end` on a connected input clears its `grant_valid`, its `grant_port` and the output's `out_busy` at the next edge. The freed output can be granted again at the edge after that.
- R8: `pkt_end` on an unconnected input has no effect. A request from an input that is already connected is ignored.
- R9: No output is ever granted while busy, and an output is never held by more than one input.
- R10: An input that loses its first choice to another input in the same cycle retries in the following cycle with the updated free set, and may then receive a different listed output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_IN | Per-input request present |
| req_prio | input | N_IN | Per-input priority bit, 1 = high |
| req_ports | input | N_IN x N_OUT | Per-input bitmap of acceptable outputs |
| pkt_end | input | N_IN | Per-input end-of-packet pulse, releases the connection |
| grant_valid | output | N_IN | Input currently connected |
| grant_port | output | N_IN x OUT_W | Output index held by each input, 0 when unconnected |
| out_busy | output | N_OUT | Output currently connected |

## Verification
A grant shows at the ports exactly one rising edge after the request that earns it. A release shows one edge after `pkt_end`, and the freed output cannot be granted again until one edge later still. So a retrying contender only appears two cycles after the end marker. The bench changes its inputs at a falling edge and reads the outputs at the following falling edge, so each vector sees exactly one registered update. The table is chained so that these delays show up as separate rows: the release row, then the regrant row.

// File: rtl/pga_pkg.sv
package pga_pkg;

    localparam int MAX_W = 32;
    localparam int IDX_W = 5;

    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic {
        PRIO_NORMAL = 1'b0,
        PRIO_HIGH   = 1'b1
    } prio_e;

    // First set bit of mask at or after start, wrapping at n.
    function automatic idx_t rr_pick(input logic [MAX_W-1:0] mask,
                                     input idx_t start,
                                     input int n);
        idx_t pick  = '0;
        logic found = 1'b0;
        int   idx;
        for (int k = 0; k < MAX_W; k++) begin
            if (k < n) begin
                idx = int'(start) + k;
                if (idx >= n) idx = idx - n;
                if (!found && mask[idx]) begin
                    found = 1'b1;
                    pick  = idx_t'(idx);
                end
            end
        end
        return pick;
    endfunction

    function automatic logic [MAX_W-1:0] to_onehot(input idx_t i);
        return MAX_W'(1) << i;
    endfunction

endpackage

// File: rtl/pga_port_pick.sv
module pga_port_pick #(
    parameter int N_OUT = 4
) (
    input  logic [N_OUT-1:0] want,
    input  logic [N_OUT-1:0] free,
    output logic [N_OUT-1:0] target
);

    logic [N_OUT-1:0] avail;

    always_comb begin
        avail  = want & free;
        // isolate the lowest listed free output
        target = avail & (~avail + N_OUT'(1));
    end

endmodule

// File: rtl/pga_out_arb.sv
module pga_out_arb
    import pga_pkg::*;
#(
    parameter int N_IN = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] cand,
    input  logic [N_IN-1:0] high,
    input  logic            busy,
    output logic [N_IN-1:0] gnt
);

    idx_t            ptr_q;
    idx_t            pick;
    logic [N_IN-1:0] hi_cand;
    logic [N_IN-1:0] pool;
    logic [MAX_W-1:0] pool_w;
    prio_e           level;

    always_comb begin
        hi_cand = cand & high;
        level   = (|hi_cand) ? PRIO_HIGH : PRIO_NORMAL;
        pool    = (level == PRIO_HIGH) ? hi_cand : cand;
        pool_w  = '0;
        pool_w[N_IN-1:0] = pool;
        pick    = rr_pick(pool_w, ptr_q, N_IN);
        gnt     = '0;
        if (!busy && (|pool)) gnt = N_IN'(to_onehot(pick));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (|gnt) begin
            ptr_q <= (int'(pick) == N_IN - 1) ? '0 : pick + idx_t'(1);
        end
    end

    // R9
    gnt_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R9
    gnt_onto_free_chk: assert property (@(posedge clk) disable iff (rst)
        (|gnt) |-> !busy);

    // R4
    gnt_prio_chk: assert property (@(posedge clk) disable iff (rst)
        ((|(cand & high)) && (|gnt)) |-> (|(gnt & high)));

endmodule

// File: rtl/pga_conn_table.sv
module pga_conn_table #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    parameter int OUT_W = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_OUT-1:0][N_IN-1:0] gnt,
    input  logic [N_IN-1:0]            eop,
    output logic [N_IN-1:0]            live,
    output logic [N_IN-1:0][OUT_W-1:0] port,
    output logic [N_OUT-1:0]           busy
);

    logic [N_IN-1:0]            live_q;
    logic [N_IN-1:0][OUT_W-1:0] port_q;
    logic [N_OUT-1:0]           busy_q;
    logic [N_IN-1:0]            rel;
    logic [N_IN-1:0]            won;
    logic [N_IN-1:0][OUT_W-1:0] won_port;
    logic [N_OUT-1:0]           drop;
    logic [N_OUT-1:0]           taken;

    always_comb begin
        rel      = live_q & eop;
        won      = '0;
        won_port = '0;
        drop     = '0;
        taken    = '0;
        for (int o = 0; o < N_OUT; o++) begin
            taken[o] = |gnt[o];
            for (int i = 0; i < N_IN; i++) begin
                if (gnt[o][i]) begin
                    won[i]      = 1'b1;
                    won_port[i] = OUT_W'(o);
                end
                if (rel[i] && (port_q[i] == OUT_W'(o))) drop[o] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            port_q <= '0;
            busy_q <= '0;
        end else begin
            for (int i = 0; i < N_IN; i++) begin
                if (rel[i]) begin
                    live_q[i] <= 1'b0;
                    port_q[i] <= '0;
                end else if (won[i]) begin
                    live_q[i] <= 1'b1;
                    port_q[i] <= won_port[i];
                end
            end
            busy_q <= (busy_q & ~drop) | taken;
        end
    end

    assign live = live_q;
    assign port = port_q;
    assign busy = busy_q;

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_chk
        // R6
        hold_until_end_chk: assert property (@(posedge clk) disable iff (rst)
            (live_q[gi] && !eop[gi]) |=> (live_q[gi] && $stable(port_q[gi])));

        // R7
        release_on_end_chk: assert property (@(posedge clk) disable iff (rst)
            (live_q[gi] && eop[gi]) |=> !live_q[gi]);
    end

    // R9
    busy_matches_links_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(busy_q) == $countones(live_q));

endmodule

// File: rtl/prio_group_arbiter.sv
module prio_group_arbiter
    import pga_pkg::*;
#(
    parameter int  N_IN  = 4,
    parameter int  N_OUT = 4,
    localparam int OUT_W = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_IN-1:0]            req_valid,
    input  logic [N_IN-1:0]            req_prio,
    input  logic [N_IN-1:0][N_OUT-1:0] req_ports,
    input  logic [N_IN-1:0]            pkt_end,
    output logic [N_IN-1:0]            grant_valid,
    output logic [N_IN-1:0][OUT_W-1:0] grant_port,
    output logic [N_OUT-1:0]           out_busy
);

    logic [N_IN-1:0]            live;
    logic [N_IN-1:0][OUT_W-1:0] link_port;
    logic [N_OUT-1:0]           busy;
    logic [N_OUT-1:0]           free;
    logic [N_IN-1:0][N_OUT-1:0] target;
    logic [N_OUT-1:0][N_IN-1:0] cand;
    logic [N_OUT-1:0][N_IN-1:0] gnt;

    assign free = ~busy;

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
        logic [N_OUT-1:0] want;
        logic [N_OUT-1:0] col;

        assign want = (req_valid[gi] && !live[gi]) ? req_ports[gi] : '0;

        pga_port_pick #(.N_OUT(N_OUT)) u_pick (
            .want   (want),
            .free   (free),
            .target (target[gi])
        );

        for (genvar go = 0; go < N_OUT; go++) begin : g_col
            assign col[go] = gnt[go][gi];
        end

        // R9
        one_output_per_input_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(col));
    end

    for (genvar go = 0; go < N_OUT; go++) begin : g_out
        for (genvar gi = 0; gi < N_IN; gi++) begin : g_map
            assign cand[go][gi] = target[gi][go];
        end

        pga_out_arb #(.N_IN(N_IN)) u_arb (
            .clk  (clk),
            .rst  (rst),
            .cand (cand[go]),
            .high (req_prio),
            .busy (busy[go]),
            .gnt  (gnt[go])
        );
    end

    pga_conn_table #(
        .N_IN  (N_IN),
        .N_OUT (N_OUT),
        .OUT_W (OUT_W)
    ) u_tab (
        .clk  (clk),
        .rst  (rst),
        .gnt  (gnt),
        .eop  (pkt_end),
        .live (live),
        .port (link_port),
        .busy (busy)
    );

    assign grant_valid = live;
    assign grant_port  = link_port;
    assign out_busy    = busy;

endmodule

// File: tb/prio_group_arbiter_bench.sv
`timescale 1ns/1ps
module prio_group_arbiter_bench;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [3:0]       req_valid = '0;
    logic [3:0]       req_prio  = '0;
    logic [3:0][3:0]  req_ports = '0;
    logic [3:0]       pkt_end   = '0;
    logic [3:0]       grant_valid;
    logic [3:0][1:0]  grant_port;
    logic [3:0]       out_busy;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    prio_group_arbiter #(.N_IN(4), .N_OUT(4)) u_prio_group_arbiter (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_prio    (req_prio),
        .req_ports   (req_ports),
        .pkt_end     (pkt_end),
        .grant_valid (grant_valid),
        .grant_port  (grant_port),
        .out_busy    (out_busy)
    );

    typedef struct packed {
        logic [3:0]  rv;
        logic [3:0]  pr;
        logic [15:0] ports;
        logic [3:0]  eop;
        logic [3:0]  gv;
        logic [7:0]  gp;
        logic [3:0]  busy;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{4'b0001, 4'b0000, 16'h0001, 4'b0000, 4'b0001, 8'h00, 4'b0001, 4'd2},  // R2 first grant
        '{4'b1110, 4'b0000, 16'h1110, 4'b0000, 4'b0001, 8'h00, 4'b0001, 4'd6},  // R6 held output
        '{4'b1110, 4'b0000, 16'h1110, 4'b0001, 4'b0000, 8'h00, 4'b0000, 4'd7},  // R7 release
        '{4'b1110, 4'b0000, 16'h1110, 4'b0000, 4'b0010, 8'h00, 4'b0001, 4'd5},  // R5 ptr at 1
        '{4'b1100, 4'b0000, 16'h1100, 4'b0010, 4'b0000, 8'h00, 4'b0000, 4'd7},  // R7
        '{4'b1100, 4'b1000, 16'h1100, 4'b0000, 4'b1000, 8'h00, 4'b0001, 4'd4},  // R4 high beats ptr
        '{4'b0011, 4'b0000, 16'h0067, 4'b0000, 4'b1001, 8'h01, 4'b0011, 4'd3},  // R3 first free
        '{4'b0010, 4'b0000, 16'h0060, 4'b0000, 4'b1011, 8'h09, 4'b0111, 4'd10}, // R10 retry
        '{4'b0100, 4'b0000, 16'h0600, 4'b0000, 4'b1011, 8'h09, 4'b0111, 4'd9},  // R9 all busy
        '{4'b0100, 4'b0000, 16'h0600, 4'b0010, 4'b1001, 8'h01, 4'b0011, 4'd7},  // R7
        '{4'b0100, 4'b0000, 16'h0600, 4'b0000, 4'b1101, 8'h21, 4'b0111, 4'd3},  // R3 waits then wins
        '{4'b0000, 4'b0000, 16'h0000, 4'b0010, 4'b1101, 8'h21, 4'b0111, 4'd8},  // R8 stray end
        '{4'b0001, 4'b0000, 16'h0008, 4'b0000, 4'b1101, 8'h21, 4'b0111, 4'd8},  // R8 live input
        '{4'b0000, 4'b0000, 16'h0000, 4'b1101, 4'b0000, 8'h00, 4'b0000, 4'd7},  // R7 multi release
        '{4'b1111, 4'b0000, 16'h8888, 4'b0000, 4'b0001, 8'h03, 4'b1000, 4'd5},  // R5 ptr 0
        '{4'b1110, 4'b0000, 16'h8880, 4'b0001, 4'b0000, 8'h00, 4'b0000, 4'd7},  // R7
        '{4'b1110, 4'b0000, 16'h8880, 4'b0000, 4'b0010, 8'h0C, 4'b1000, 4'd5},  // R5 ptr 1
        '{4'b1100, 4'b0000, 16'h8800, 4'b0010, 4'b0000, 8'h00, 4'b0000, 4'd7},  // R7
        '{4'b1100, 4'b0000, 16'h8800, 4'b0000, 4'b0100, 8'h30, 4'b1000, 4'd5},  // R5 ptr 2
        '{4'b1001, 4'b0000, 16'h8008, 4'b0100, 4'b0000, 8'h00, 4'b0000, 4'd7},  // R7
        '{4'b1001, 4'b0000, 16'h8008, 4'b0000, 4'b1000, 8'hC0, 4'b1000, 4'd5},  // R5 ptr 3
        '{4'b1001, 4'b0000, 16'h8008, 4'b1000, 4'b0000, 8'h00, 4'b0000, 4'd7},  // R7
        '{4'b1001, 4'b0000, 16'h8008, 4'b0000, 4'b0001, 8'h03, 4'b1000, 4'd5},  // R5 wrap
        '{4'b0000, 4'b0000, 16'h0000, 4'b0001, 4'b0000, 8'h00, 4'b0000, 4'd7},  // R7
        '{4'b1111, 4'b0010, 16'h2211, 4'b0000, 4'b0110, 8'h10, 4'b0011, 4'd4}   // R4 two outputs
    };

    task automatic check(input string what, input int req,
                         input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input int req,
                             input logic [3:0] gv, input logic [7:0] gp,
                             input logic [3:0] busy);
        check({tag, " grant_valid"}, req, 16'(grant_valid), 16'(gv));
        check({tag, " grant_port"},  req, 16'(grant_port),  16'(gp));
        check({tag, " out_busy"},    req, 16'(out_busy),    16'(busy));
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check_all("reset", 1, 4'b0000, 8'h00, 4'b0000);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            req_valid = VEC[v].rv;
            req_prio  = VEC[v].pr;
            req_ports = VEC[v].ports;
            pkt_end   = VEC[v].eop;
            @(negedge clk);
            check_all($sformatf("vector %0d", v), int'(VEC[v].req),
                      VEC[v].gv, VEC[v].gp, VEC[v].busy);
        end

        // R1 mid-run reset clears links and rotation pointers
        rst = 1'b1;
        req_valid = '0; req_prio = '0; req_ports = '0; pkt_end = '0;
        @(negedge clk);
        @(negedge clk);
        check_all("mid reset", 1, 4'b0000, 8'h00, 4'b0000);

        // R1 pointer restarts at input 0: inputs 1 and 3 contend for output 0
        rst = 1'b0;
        req_valid = 4'b1010;
        req_ports = 16'h1010;
        @(negedge clk);
        check_all("pointer after reset", 1, 4'b0010, 8'h00, 4'b0001);

        // R2 a further request to a different free output, one cycle later
        req_valid = 4'b1000;
        req_ports = 16'h4000;
        @(negedge clk);
        check_all("second output", 2, 4'b1010, 8'h80, 4'b0101);

        req_valid = '0;
        req_ports = '0;
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule